// File: doc/BRIEF.md
# Configurable Burst Read Controller

This block sits between a bus master and a memory array and decides, cycle by cycle, which array word is read, when the word is presented on the output and when the WAIT pin tells the master to hold off. A 16-bit configuration word selects the behaviour. The word sets asynchronous page access or synchronous burst access, the initial latency, the WAIT polarity and lead, how long each beat is held, the address order and the wrap size. The master loads the word through a load strobe. Each read starts with an address-latch strobe that carries the start address.

The array is combinational as seen from this block: `arr_addr` comes from registered state, and the array answers on `arr_rdata` in the same cycle. That word goes straight to `dout_data`, qualified by `dout_valid`. The output stream has no back-pressure. The read timing is fixed by the configuration, so the consumer must take every cycle in which `dout_valid` is high.

The configuration word is copied into a working snapshot only when an address is latched. A burst therefore always runs with the settings that were in force when it started. Bit 6 (active clock edge) is stored in the register and the snapshot. The clocking that uses it lies outside this block.

Top module: `rbc_burst_reader`

## Requirements
- R1: After reset the configuration word is 16'h9DC7. This gives asynchronous mode, latency code 3, WAIT active high with one cycle of lead, one-cycle beats, sequential order, no wrap and continuous length. `dout_valid` stays low until the first address latch, and the WAIT pin is low.
- R2: With bit 15 = 1 in the snapshot, `dout_valid` is high from the cycle after the latching edge until the next latch. `arr_addr` equals the start address, `dout_data` equals `arr_rdata`, and WAIT stays inactive.
- R3: With bit 15 = 0, the code L in bits 13:11 (codes 0 and 1 count as 2) sets the first valid beat. It appears in the cycle that follows the L-th rising edge after the latching edge.
- R4: Bit 9 = 0 holds each beat for one cycle. Bit 9 = 1 holds each beat for two cycles, with `arr_addr` unchanged across both cycles.
- R5: Bits 2:0 set the length: 001 gives 4 beats and 010 gives 8 beats. Any other code runs continuously. After the last beat of a fixed burst, `dout_valid` falls and WAIT is inactive.
- R6: With bit 7 = 1 and bit 3 = 1, beat k of a fixed burst reads the aligned block base plus ((start offset + k) mod N).
- R7: With bit 7 = 1 and bit 3 = 0, beat k of a fixed burst reads start + k and crosses the block boundary.
- R8: With bit 7 = 0, beat k of a fixed burst reads the aligned block base plus (start offset XOR k). The burst stays inside the block whatever the value of bit 3.
- R9: A continuous burst reads start + k on beat k and ignores bits 7 and 3.
- R10: In synchronous mode WAIT is logically asserted from the latching edge up to the first valid beat. With bit 8 = 1 it deasserts one cycle earlier, so it is never asserted in the cycle just before the first beat.
- R11: Bit 10 = 1 drives WAIT active high and bit 10 = 0 drives it active low. Whenever WAIT is not asserted, the pin sits at the inactive level of the snapshot polarity.
- R12: A configuration load changes nothing in a burst that is already running. The load applies from the next address latch. A load in the same cycle as a latch applies only from the following latch.
- R13: An address latch during a burst abandons that burst and restarts the latency count from the new start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word to load |
| adv_valid | input | 1 | Address-latch strobe; starts a read |
| adv_addr | input | ADDR_W | Start address |
| arr_addr | output | ADDR_W | Address presented to the array |
| arr_rdata | input | DATA_W | Array read data for `arr_addr` |
| dout_valid | output | 1 | Output beat qualifier |
| dout_data | output | DATA_W | Output data |
| wait_o | output | 1 | WAIT pin, programmable polarity |

## Verification
The latching edge is counted as edge 0. In synchronous mode the first beat is due in the cycle after edge L, and beat k is due in the cycle after edge L + k·H, where H is 1 or 2. The WAIT level is due in the cycle after each edge, and an asynchronous read is due in the cycle right after edge 0. The bench counts edges since the latch in a behavioural model, which it updates on each rising edge. It drives inputs 2 ns after that edge and compares every output at the falling edge, so each check falls in the middle of the cycle in which its result is due.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  // Register layout: the packed order is the bit order of the configuration word.
  typedef struct packed {
    logic       async_rd;   // 15
    logic       rsvd_hi;    // 14
    logic [2:0] lat;        // 13:11
    logic       wait_hi;    // 10
    logic       hold2;      // 9
    logic       wait_lead;  // 8
    logic       seq;        // 7
    logic       rise_edge;  // 6
    logic [1:0] rsvd_lo;    // 5:4
    logic       wrap;       // 3
    logic [2:0] blen;       // 2:0
  } rbc_cfg_t;

  localparam logic [15:0] CFG_RESET = 16'h9DC7;
  localparam logic [2:0]  LEN_4     = 3'b001;
  localparam logic [2:0]  LEN_8     = 3'b010;
  localparam logic [2:0]  LAT_FLOOR = 3'd2;

  function automatic logic [2:0] eff_latency(input logic [2:0] code);
    return (code < LAT_FLOOR) ? LAT_FLOOR : code;
  endfunction

  function automatic logic is_fixed(input logic [2:0] code);
    return (code == LEN_4) || (code == LEN_8);
  endfunction

endpackage

// File: rtl/rbc_cfg_reg.sv
module rbc_cfg_reg
  import rbc_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_W'(CFG_RESET);
    else if (load) cfg_q <= wdata;
  end

  // R12
  load_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cfg_q == $past(wdata)));

endmodule

// File: rtl/rbc_beat_timer.sv
module rbc_beat_timer
  import rbc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_async,
  input  logic [2:0]        lat_code,
  input  logic              hold2,
  input  logic              wait_lead,
  input  logic [2:0]        blen,
  output logic              beat_valid,
  output logic              wait_act,
  output logic [ADDR_W-1:0] beat
);

  logic              run_q;
  logic              async_q;
  logic [2:0]        ph_q;
  logic              sub_q;
  logic [2:0]        lat_eff;
  logic [2:0]        wait_end;
  logic              fixed;
  logic [ADDR_W-1:0] last_beat;
  logic              in_data;

  always_comb begin
    lat_eff   = eff_latency(lat_code);
    wait_end  = wait_lead ? (lat_eff - 3'd1) : lat_eff;
    fixed     = is_fixed(blen);
    last_beat = (blen == LEN_8) ? ADDR_W'(7) : ADDR_W'(3);
    in_data   = run_q && (ph_q == lat_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      async_q <= 1'b0;
      ph_q    <= '0;
      sub_q   <= 1'b0;
      beat    <= '0;
    end else if (start) begin
      run_q   <= !start_async;
      async_q <= start_async;
      ph_q    <= '0;
      sub_q   <= 1'b0;
      beat    <= '0;
    end else if (run_q) begin
      if (ph_q != lat_eff) begin
        ph_q <= ph_q + 3'd1;
      end else if (!hold2 || sub_q) begin
        sub_q <= 1'b0;
        if (fixed && (beat == last_beat)) run_q <= 1'b0;
        else beat <= beat + ADDR_W'(1);
      end else begin
        sub_q <= 1'b1;
      end
    end
  end

  assign beat_valid = async_q || in_data;
  assign wait_act   = run_q && (ph_q < wait_end);

  // R4
  hold_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && hold2 && !sub_q && !start) |=> (beat_valid && $stable(beat)));

  // R10
  wait_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(beat_valid) && !async_q) |-> ($past(wait_act) == !wait_lead));

  // R5
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && fixed) |-> (beat <= last_beat));

  // R3
  no_early_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !start_async) |=> !beat_valid);

endmodule

// File: rtl/rbc_addr_gen.sv
module rbc_addr_gen
  import rbc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] beat,
  input  logic              seq,
  input  logic              wrap,
  input  logic [2:0]        blen,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] MASK4 = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] MASK8 = ADDR_W'(7);

  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] linear;
  logic              fixed;

  always_comb begin
    mask   = (blen == LEN_8) ? MASK8 : MASK4;
    linear = base + beat;
    fixed  = is_fixed(blen);
    if (!fixed)
      addr = linear;
    else if (!seq)
      addr = (base & ~mask) | ((base ^ beat) & mask);
    else if (wrap)
      addr = (base & ~mask) | (linear & mask);
    else
      addr = linear;
  end

  // R8
  block_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed && (!seq || wrap)) |-> ((addr & ~mask) == (base & ~mask)));

endmodule

// File: rtl/rbc_burst_reader.sv
module rbc_burst_reader
  import rbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [15:0]       cfg_wdata,
  input  logic              adv_valid,
  input  logic [ADDR_W-1:0] adv_addr,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              dout_valid,
  output logic [DATA_W-1:0] dout_data,
  output logic              wait_o
);

  logic [15:0]       cfg_q;
  rbc_cfg_t          live_cfg;
  rbc_cfg_t          act_cfg;
  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] beat;
  logic              wait_act;

  rbc_cfg_reg #(.CFG_W(16)) i_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .wdata (cfg_wdata),
    .cfg_q (cfg_q)
  );

  assign live_cfg = rbc_cfg_t'(cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cfg <= rbc_cfg_t'(CFG_RESET);
      start_q <= '0;
    end else if (adv_valid) begin
      act_cfg <= live_cfg;
      start_q <= adv_addr;
    end
  end

  rbc_beat_timer #(.ADDR_W(ADDR_W)) i_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (adv_valid),
    .start_async (live_cfg.async_rd),
    .lat_code    (act_cfg.lat),
    .hold2       (act_cfg.hold2),
    .wait_lead   (act_cfg.wait_lead),
    .blen        (act_cfg.blen),
    .beat_valid  (dout_valid),
    .wait_act    (wait_act),
    .beat        (beat)
  );

  rbc_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .base  (start_q),
    .beat  (beat),
    .seq   (act_cfg.seq),
    .wrap  (act_cfg.wrap),
    .blen  (act_cfg.blen),
    .addr  (arr_addr)
  );

  assign dout_data = arr_rdata;
  assign wait_o    = act_cfg.wait_hi ? wait_act : !wait_act;

  // R12
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_valid |=> $stable(act_cfg));

  // R2
  async_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && act_cfg.async_rd && !adv_valid) |=> (dout_valid && $stable(arr_addr)));

  // R11
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (wait_o == !act_cfg.wait_hi));

endmodule

// File: tb/test_rbc_burst_reader.sv
module test_rbc_burst_reader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        adv_valid = 1'b0;
  logic [15:0] adv_addr = '0;
  logic [15:0] arr_addr;
  logic [15:0] arr_rdata;
  logic        dout_valid;
  logic [15:0] dout_data;
  logic        wait_o;

  always #4 clk = !clk;

  assign arr_rdata = {arr_addr[7:0], arr_addr[15:8]} ^ 16'h3C5A;

  rbc_burst_reader i_rbc_burst_reader (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_wdata(cfg_wdata),
    .adv_valid(adv_valid), .adv_addr(adv_addr), .arr_addr(arr_addr),
    .arr_rdata(arr_rdata), .dout_valid(dout_valid), .dout_data(dout_data),
    .wait_o(wait_o)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    chk_en = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [15:0] m_reg, m_cfg, m_start;
  int          since;
  bit          m_started;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 16'h9DC7; m_cfg = 16'h9DC7; m_start = '0; since = 0; m_started = 0;
    end else begin
      if (adv_valid) begin
        m_cfg = m_reg; m_start = adv_addr; since = 0; m_started = 1;
      end else if (m_started) begin
        since++;
      end
      if (cfg_load) m_reg = cfg_wdata;
    end
  end

  function automatic logic [15:0] ref_addr(logic [15:0] s, int k, logic [15:0] c);
    int n, off;
    n = (c[2:0] == 3'b001) ? 4 : (c[2:0] == 3'b010) ? 8 : 0;
    if (n == 0) return s + 16'(k);
    off = int'(s) % n;
    if (!c[7]) return (s - 16'(off)) + 16'(off ^ k);
    if (c[3])  return (s - 16'(off)) + 16'((off + k) % n);
    return s + 16'(k);
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      int  lat, hh, n, k;
      bit  ev, ew, epin;
      logic [15:0] ea;
      lat = (int'(m_cfg[13:11]) < 2) ? 2 : int'(m_cfg[13:11]);
      hh  = m_cfg[9] ? 2 : 1;
      n   = (m_cfg[2:0] == 3'b001) ? 4 : (m_cfg[2:0] == 3'b010) ? 8 : 0;
      ev = 0; ew = 0; ea = m_start;
      if (!m_started || !rst_n) begin
        ev = 0; ew = 0;
      end else if (m_cfg[15]) begin
        ev = 1; ea = m_start;
      end else if (since < lat) begin
        ew = since < (m_cfg[8] ? lat - 1 : lat);
      end else begin
        k  = (since - lat) / hh;
        ev = (n == 0) || (k < n);
        ea = ref_addr(m_start, k, m_cfg);
      end
      epin = m_cfg[10] ? ew : !ew;
      chk(dout_valid == ev, "dout_valid", int'(dout_valid), int'(ev));
      chk(wait_o == epin, "wait_o", int'(wait_o), int'(epin));
      if (ev) begin
        chk(arr_addr == ea, "arr_addr", int'(arr_addr), int'(ea));
        chk(dout_data == ({ea[7:0], ea[15:8]} ^ 16'h3C5A), "dout_data",
            int'(dout_data), int'({ea[7:0], ea[15:8]} ^ 16'h3C5A));
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic load(logic [15:0] v);
    cfg_load = 1'b1; cfg_wdata = v; step(1); cfg_load = 1'b0;
  endtask

  task automatic latch(logic [15:0] a);
    adv_valid = 1'b1; adv_addr = a; step(1); adv_valid = 1'b0;
  endtask

  function automatic logic [15:0] mk(bit asy, int lat, bit pol, bit h2, bit lead,
                                     bit sq, bit wr, int len);
    logic [15:0] v;
    v = 16'h0040;
    v[15] = asy; v[13:11] = lat[2:0]; v[10] = pol; v[9] = h2; v[8] = lead;
    v[7] = sq; v[3] = wr; v[2:0] = len[2:0];
    return v;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog %s act=hung exp=finished", cur_req);
      finish_run();
    end
  end

  initial begin
    cur_req = "R1";
    @(posedge clk); #2; chk_en = 1;
    step(2); rst_n = 1'b1; step(4);

    cur_req = "R2";
    latch(16'h1234); step(5); latch(16'h0042); step(3);

    cur_req = "R6";
    load(mk(0, 3, 1, 0, 0, 1, 1, 1)); latch(16'h0106); step(10);
    load(mk(0, 2, 1, 0, 0, 1, 1, 2)); latch(16'h00AD); step(14);

    cur_req = "R8";
    load(mk(0, 2, 1, 0, 0, 0, 1, 2)); latch(16'h0013); step(14);
    load(mk(0, 3, 1, 0, 0, 0, 0, 1)); latch(16'h002D); step(10);

    cur_req = "R7";
    load(mk(0, 4, 1, 0, 0, 1, 0, 1)); latch(16'h00FE); step(10);

    cur_req = "R4";
    load(mk(0, 5, 1, 1, 1, 1, 1, 2)); latch(16'h0035); step(26);

    cur_req = "R9";
    load(mk(0, 7, 1, 1, 0, 0, 1, 7)); latch(16'h0FFE); step(30);

    cur_req = "R10";
    load(mk(0, 6, 1, 0, 1, 1, 0, 1)); latch(16'h0400); step(12);
    load(mk(0, 6, 1, 0, 0, 1, 0, 1)); latch(16'h0410); step(12);

    cur_req = "R11";
    load(mk(0, 3, 0, 0, 1, 1, 1, 1)); latch(16'h0502); step(12);
    load(mk(0, 4, 0, 0, 0, 1, 1, 2)); latch(16'h0507); step(16);

    cur_req = "R3";
    load(mk(0, 0, 1, 0, 0, 1, 1, 1)); latch(16'h0600); step(8);
    load(mk(0, 1, 1, 0, 1, 1, 1, 1)); latch(16'h0604); step(8);

    cur_req = "R5";
    load(mk(0, 2, 1, 0, 0, 1, 1, 4)); latch(16'h0700); step(16);

    cur_req = "R12";
    load(mk(0, 3, 1, 0, 0, 1, 1, 2)); latch(16'h0800); step(2);
    load(mk(0, 6, 0, 1, 1, 1, 0, 1)); step(10);
    latch(16'h0810); step(14);
    cfg_load = 1'b1; cfg_wdata = mk(1, 2, 1, 0, 1, 1, 0, 7);
    adv_valid = 1'b1; adv_addr = 16'h0820; step(1);
    cfg_load = 1'b0; adv_valid = 1'b0; step(14);
    latch(16'h0830); step(4);

    cur_req = "R13";
    load(mk(0, 4, 1, 0, 0, 1, 0, 7)); latch(16'h0200); step(7);
    latch(16'h0300); step(3); latch(16'h0340); step(10);

    finish_run();
  end

endmodule